// File: doc/BRIEF.md
# Four-Channel Serial Port Host Register Front End

This block is the processor side of a four-channel asynchronous serial controller. A host reaches one channel at a time by pulling that channel's active-low select low. It then places a 3-bit register address and pulses an active-low read or write strobe against an 8-bit data bus. Each channel keeps four registers: interrupt enables, a one-bit flow-control option, modem control and modem status. The block drives the channel's active-low terminal-ready pin and samples the active-low clear-to-send, data-set-ready and carrier pins. It also produces an interrupt line and an enable for that line, a prescaled baud enable, and a flag that tells the transmitter whether it may start a character.

Receive and transmit status comes from the serial datapath as plain level flags. Bus and interrupt pins that would be tri-stated on a board are modelled here as a data output and an output enable. Strobes are sampled on the block clock. A write stays active for every cycle its strobe is low, and the same value is stored each time.

The prescaler choice comes from a strap input. The strap is captured inverted on the last clock of reset, and software may rewrite it later.

Top module: `quad_uart_host_if`

## Requirements
- R1: While `wr_n` is low, each channel whose `cs_n` bit is low stores `wdata` into the register at `addr`. Address 1 holds the interrupt enables in bits 3:0 and reads back with bits 7:4 as zero. Channels whose select is high keep their contents.
- R2: `rdata_oe` is 1 exactly while `rd_n` is low and at least one `cs_n` bit is low. `rdata` then shows the addressed register of the lowest-numbered selected channel, and shows 0 otherwise.
- R3: Modem control (address 4) bit 7 selects the prescaler, with 1 meaning divide-by-4. On the last clock of reset it takes the inverse of `clksel`, and a later write may change it.
- R4: `dtr_n` of a channel is the inverse of its modem control bit 0, so it is high after reset.
- R5: `irq_oe` of a channel is 1 when its modem control bit 3 is 1 or `intsel` is 1. With `intsel` low it is 0 after reset.
- R6: `irq` of a channel is 1 when an enabled condition holds. Enable bit 0 pairs with `rx_avail`, bit 1 with `tx_empty`, bit 2 with `rx_err`, and bit 3 with any modem status delta flag.
- R7: Modem status (address 6) shows the inverted synchronized pin levels: bit 4 for clear-to-send, bit 5 for data-set-ready and bit 7 for carrier, with bit 6 always 0. A pin change appears two clocks after it is sampled.
- R8: Status bits 0, 1 and 3 are delta flags for clear-to-send, data-set-ready and carrier, and bit 2 is always 0. A flag sets one clock after its level bit changes. Flags clear on the clock after a status read of that channel ends, and a new change in that clock wins over the clear.
- R9: `baud_en` is 1 every clock in divide-by-1. In divide-by-4 it pulses once every fourth clock. The first clock after reset, or after bit 7 changes, counts as phase 0, and the pulse comes in phase 3.
- R10: Bit 7 of address 2 enables automatic flow control and reads back with bits 6:0 as zero. While it is 1 and the synchronized clear-to-send pin is high, `tx_allowed` is 0. Otherwise `tx_allowed` is 1.
- R11: Writes to address 6 and to addresses 0, 3, 5 and 7 change nothing, and those unmapped addresses read as 0. A write with several selects low reaches every selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clksel | input | 1 | Prescaler strap, captured inverted during reset |
| intsel | input | 1 | Forces all interrupt output enables on |
| cs_n | input | 4 | Per-channel active-low select |
| addr | input | 3 | Register address within a channel |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data, bit 0 least significant |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data bus enable |
| cts_n | input | 4 | Active-low clear-to-send per channel |
| dsr_n | input | 4 | Active-low data-set-ready per channel |
| cd_n | input | 4 | Active-low carrier detect per channel |
| dtr_n | output | 4 | Active-low terminal-ready per channel |
| rx_avail | input | 4 | Receive data available flag per channel |
| tx_empty | input | 4 | Transmit buffer empty flag per channel |
| rx_err | input | 4 | Receive error flag per channel |
| irq | output | 4 | Active-high interrupt per channel |
| irq_oe | output | 4 | Interrupt output enable per channel |
| baud_en | output | 4 | Prescaled baud clock enable per channel |
| tx_allowed | output | 4 | Transmitter may start a character |

## Verification
A control bit stored wrongly shows up at once at a pin: `dtr_n`, `irq_oe`, `tx_allowed` or the `baud_en` cadence differ one clock after the write. A wrong interrupt enable shows on `irq` as soon as the paired flag changes. A bad prescaler phase shows within four clocks. Status pipeline or delta-flag errors only surface on a later status read or through `irq`, so the bench compares every output against a model on every clock and reads the status register after each pin change.

// File: rtl/uhif_pkg.sv
package uhif_pkg;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] A_IER = 3'd1;
   localparam logic [ADDR_W-1:0] A_EFR = 3'd2;
   localparam logic [ADDR_W-1:0] A_MCR = 3'd4;
   localparam logic [ADDR_W-1:0] A_MSR = 3'd6;

   localparam int MCR_DTR  = 0;
   localparam int MCR_IRQ  = 3;
   localparam int MCR_DIV  = 7;
   localparam int EFR_ACTS = 7;

   localparam int IER_W = 4;
endpackage

// File: rtl/uhif_sync.sv
module uhif_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("uhif_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/uhif_prescale.sv
module uhif_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_sel,
   output logic baud_en
);
   localparam int CW = $clog2(DIV);

   generate
      if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
         $error("uhif_prescale: DIV must be a power of two, at least 2");
      end
   endgenerate

   logic          sel_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] eff;

   assign eff     = (div_sel != sel_q) ? '0 : cnt;
   assign baud_en = div_sel ? (eff == CW'(DIV - 1)) : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= div_sel;
      end else begin
         sel_q <= div_sel;
         cnt   <= eff + 1'b1;
      end
   end

   // R9: in divide mode a pulse is never followed by another one
   p_div_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_en && div_sel) |=> (!baud_en || !div_sel));
endmodule

// File: rtl/uhif_chan.sv
module uhif_chan
   import uhif_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_act,
   input  logic              wr_act,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clksel,
   input  logic              intsel,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              cd_n,
   input  logic              rx_avail,
   input  logic              tx_empty,
   input  logic              rx_err,
   output logic [DATA_W-1:0] rd_val,
   output logic              dtr_n,
   output logic              irq,
   output logic              irq_oe,
   output logic              baud_en,
   output logic              tx_allowed
);
   logic             wr_hit, rd_msr, rd_msr_q, rd_end;
   logic [IER_W-1:0] ier;
   logic             efr_acts, mcr_dtr, mcr_irq, mcr_div;
   logic [2:0]       pin_n, lvl, lvl_q, chg;
   logic [3:0]       delta, delta_set;
   logic [DATA_W-1:0] msr;
   logic             unused_wbits;

   assign unused_wbits = ^wdata[6:4];
   assign pin_n = {cd_n, dsr_n, cts_n};

   uhif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_n),
      .q     (lvl)
   );

   uhif_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (mcr_div),
      .baud_en (baud_en)
   );

   assign wr_hit    = sel & wr_act;
   assign rd_msr    = sel & rd_act & (addr == A_MSR);
   assign rd_end    = rd_msr_q & ~rd_msr;
   assign chg       = lvl ^ lvl_q;
   assign delta_set = {chg[2], 1'b0, chg[1], chg[0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ier      <= '0;
         efr_acts <= 1'b0;
         mcr_dtr  <= 1'b0;
         mcr_irq  <= 1'b0;
         mcr_div  <= ~clksel;
         lvl_q    <= 3'b111;
         delta    <= '0;
         rd_msr_q <= 1'b0;
      end else begin
         if (wr_hit) begin
            case (addr)
               A_IER: ier <= wdata[IER_W-1:0];
               A_EFR: efr_acts <= wdata[EFR_ACTS];
               A_MCR: begin
                  mcr_dtr <= wdata[MCR_DTR];
                  mcr_irq <= wdata[MCR_IRQ];
                  mcr_div <= wdata[MCR_DIV];
               end
               default: ;
            endcase
         end
         lvl_q    <= lvl;
         rd_msr_q <= rd_msr;
         delta    <= (rd_end ? 4'b0000 : delta) | delta_set;
      end
   end

   assign msr = {~lvl[2], 1'b0, ~lvl[1], ~lvl[0], delta};

   always_comb begin
      case (addr)
         A_IER:   rd_val = {4'b0000, ier};
         A_EFR:   rd_val = {efr_acts, 7'b0000000};
         A_MCR:   rd_val = {mcr_div, 3'b000, mcr_irq, 2'b00, mcr_dtr};
         A_MSR:   rd_val = msr;
         default: rd_val = '0;
      endcase
   end

   assign dtr_n      = ~mcr_dtr;
   assign irq_oe     = mcr_irq | intsel;
   assign irq        = |(ier & {|delta, rx_err, tx_empty, rx_avail});
   assign tx_allowed = ~efr_acts | ~lvl[0];

   // R1: an enable write is visible in the register on the next clock
   p_ier_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr == A_IER) |=> (ier == $past(wdata[IER_W-1:0])));

   // R4: terminal-ready pin follows the written control bit
   p_dtr_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr == A_MCR) |=> (dtr_n == !$past(wdata[MCR_DTR])));

   // R5: interrupt enable follows the written bit or the force input
   p_irq_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && addr == A_MCR) |=> (irq_oe == ($past(wdata[MCR_IRQ]) | intsel)));

   // R8: end of a status read with no new change leaves no delta flag
   p_delta_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && chg == 3'b000) |=> (delta == 4'b0000));
endmodule

// File: rtl/quad_uart_host_if.sv
module quad_uart_host_if
   import uhif_pkg::*;
#(
   parameter int NCH = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clksel,
   input  logic              intsel,
   input  logic [NCH-1:0]    cs_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   input  logic [NCH-1:0]    cts_n,
   input  logic [NCH-1:0]    dsr_n,
   input  logic [NCH-1:0]    cd_n,
   output logic [NCH-1:0]    dtr_n,
   input  logic [NCH-1:0]    rx_avail,
   input  logic [NCH-1:0]    tx_empty,
   input  logic [NCH-1:0]    rx_err,
   output logic [NCH-1:0]    irq,
   output logic [NCH-1:0]    irq_oe,
   output logic [NCH-1:0]    baud_en,
   output logic [NCH-1:0]    tx_allowed
);
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("quad_uart_host_if: NCH must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] ch_rd [NCH];
   logic [DATA_W-1:0] rd_mux;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         uhif_chan #(.SYNC_STAGES(SYNC_STAGES), .PRE_DIV(PRE_DIV)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (~cs_n[c]),
            .addr       (addr),
            .rd_act     (~rd_n),
            .wr_act     (~wr_n),
            .wdata      (wdata),
            .clksel     (clksel),
            .intsel     (intsel),
            .cts_n      (cts_n[c]),
            .dsr_n      (dsr_n[c]),
            .cd_n       (cd_n[c]),
            .rx_avail   (rx_avail[c]),
            .tx_empty   (tx_empty[c]),
            .rx_err     (rx_err[c]),
            .rd_val     (ch_rd[c]),
            .dtr_n      (dtr_n[c]),
            .irq        (irq[c]),
            .irq_oe     (irq_oe[c]),
            .baud_en    (baud_en[c]),
            .tx_allowed (tx_allowed[c])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int c = NCH - 1; c >= 0; c--) begin
         if (!cs_n[c]) rd_mux = ch_rd[c];
      end
   end

   assign rdata_oe = ~rd_n & ~(&cs_n);
   assign rdata    = rdata_oe ? rd_mux : '0;
endmodule

// File: tb/sim_quad_uart_host_if.sv
module sim_quad_uart_host_if;
   logic       clk = 1'b0;
   logic       rst_n, clksel, intsel, rd_n, wr_n;
   logic [3:0] cs_n, cts_n, dsr_n, cd_n, rx_avail, tx_empty, rx_err;
   logic [2:0] addr;
   logic [7:0] wdata, rdata;
   logic       rdata_oe;
   logic [3:0] dtr_n, irq, irq_oe, baud_en, tx_allowed;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   quad_uart_host_if u0 (
      .clk(clk), .rst_n(rst_n), .clksel(clksel), .intsel(intsel),
      .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .cts_n(cts_n), .dsr_n(dsr_n),
      .cd_n(cd_n), .dtr_n(dtr_n), .rx_avail(rx_avail), .tx_empty(tx_empty),
      .rx_err(rx_err), .irq(irq), .irq_oe(irq_oe), .baud_en(baud_en),
      .tx_allowed(tx_allowed)
   );

   // behavioural reference state, one entry per channel
   logic [3:0] m_ier [4];
   logic       m_efr [4], m_dtr [4], m_ien [4], m_div [4], m_divq [4], m_rdq [4];
   logic [2:0] m_s0 [4], m_lvl [4], m_lvlq [4];
   logic [3:0] m_delta [4];
   int         m_cnt [4];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   function automatic int m_phase(input int c);
      return (m_div[c] != m_divq[c]) ? 0 : m_cnt[c];
   endfunction

   function automatic logic [7:0] m_reg(input int c, input logic [2:0] a);
      case (a)
         3'd1: return {4'h0, m_ier[c]};
         3'd2: return {m_efr[c], 7'h00};
         3'd4: return {m_div[c], 3'b000, m_ien[c], 2'b00, m_dtr[c]};
         3'd6: return {~m_lvl[c][2], 1'b0, ~m_lvl[c][1], ~m_lvl[c][0], m_delta[c]};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      for (int c = 0; c < 4; c++) begin
         if (!rst_n) begin
            m_ier[c] = 4'h0; m_efr[c] = 1'b0; m_dtr[c] = 1'b0; m_ien[c] = 1'b0;
            m_divq[c] = m_div[c]; m_div[c] = ~clksel;
            m_s0[c] = 3'b111; m_lvl[c] = 3'b111; m_lvlq[c] = 3'b111;
            m_delta[c] = 4'h0; m_rdq[c] = 1'b0; m_cnt[c] = 0;
         end else begin
            logic [2:0] ch;
            logic       now, fin;
            int         ph;
            ph = m_phase(c);
            m_cnt[c] = (ph + 1) % 4;
            m_divq[c] = m_div[c];
            ch = m_lvl[c] ^ m_lvlq[c];
            now = !cs_n[c] && !rd_n && addr == 3'd6;
            fin = m_rdq[c] && !now;
            m_delta[c] = (fin ? 4'h0 : m_delta[c]) | {ch[2], 1'b0, ch[1], ch[0]};
            m_rdq[c] = now;
            m_lvlq[c] = m_lvl[c];
            m_lvl[c] = m_s0[c];
            m_s0[c] = {cd_n[c], dsr_n[c], cts_n[c]};
            if (!cs_n[c] && !wr_n) begin
               case (addr)
                  3'd1: m_ier[c] = wdata[3:0];
                  3'd2: m_efr[c] = wdata[7];
                  3'd4: begin m_dtr[c] = wdata[0]; m_ien[c] = wdata[3]; m_div[c] = wdata[7]; end
                  default: ;
               endcase
            end
         end
      end
   end

   // every-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         logic [7:0] er;
         logic       eoe;
         eoe = !rd_n && (cs_n != 4'hF);
         er = 8'h00;
         for (int c = 3; c >= 0; c--) if (!cs_n[c] && eoe) er = m_reg(c, addr);
         chk("R2", "rdata_oe", int'(rdata_oe), int'(eoe));
         chk("R2", "rdata", int'(rdata), int'(er));
         for (int c = 0; c < 4; c++) begin
            logic ei;
            ei = |(m_ier[c] & {|m_delta[c], rx_err[c], tx_empty[c], rx_avail[c]});
            chk("R4", "dtr_n", int'(dtr_n[c]), int'(!m_dtr[c]));
            chk("R5", "irq_oe", int'(irq_oe[c]), int'(m_ien[c] | intsel));
            chk("R6", "irq", int'(irq[c]), int'(ei));
            chk("R9", "baud_en", int'(baud_en[c]), int'(m_div[c] ? (m_phase(c) == 3) : 1'b1));
            chk("R10", "tx_allowed", int'(tx_allowed[c]), int'(!(m_efr[c] && m_lvl[c][0])));
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [3:0] csn, input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      cs_n = csn; addr = a; wdata = d; wr_n = 1'b0;
      @(posedge clk); #1;
      wr_n = 1'b1; cs_n = 4'hF;
   endtask

   task automatic rd(input int c, input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      cs_n = 4'hF; cs_n[c] = 1'b0; addr = a; rd_n = 1'b0;
      @(negedge clk);
      chk(tag, "read", int'(rdata), int'(exp));
      @(posedge clk); #1;
      rd_n = 1'b1; cs_n = 4'hF;
   endtask

   task automatic count_baud(input int c, input int exp, input string tag);
      int n = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (baud_en[c]) n++;
      end
      chk(tag, "baud pulses in 16 clocks", n, exp);
   endtask

   initial begin
      rst_n = 1'b0; clksel = 1'b1; intsel = 1'b0; cs_n = 4'hF; addr = 3'd0;
      rd_n = 1'b1; wr_n = 1'b1; wdata = 8'h00;
      cts_n = 4'hF; dsr_n = 4'hF; cd_n = 4'hF;
      rx_avail = 4'h0; tx_empty = 4'h0; rx_err = 4'h0;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      // reset state
      rd(0, 3'd4, 8'h00, "R3");
      chk("R4", "dtr_n after reset", int'(dtr_n), 4'hF);
      chk("R5", "irq_oe after reset", int'(irq_oe), 4'h0);
      // control writes
      wr(4'b1110, 3'd4, 8'h89);
      rd(0, 3'd4, 8'h89, "R1");
      chk("R4", "dtr_n ch0 driven", int'(dtr_n[0]), 0);
      chk("R5", "irq_oe ch0 enabled", int'(irq_oe[0]), 1);
      wr(4'b1101, 3'd1, 8'hFF);
      rd(1, 3'd1, 8'h0F, "R1");
      rd(2, 3'd1, 8'h00, "R1");
      // multi-select write and flow-control bit
      wr(4'b0011, 3'd2, 8'hFF);
      rd(2, 3'd2, 8'h80, "R11");
      rd(3, 3'd2, 8'h80, "R11");
      rd(0, 3'd2, 8'h00, "R11");
      // ignored writes
      wr(4'b1110, 3'd6, 8'hFF);
      rd(0, 3'd6, 8'h00, "R11");
      wr(4'b1110, 3'd0, 8'h55);
      rd(0, 3'd0, 8'h00, "R11");
      rd(0, 3'd7, 8'h00, "R11");
      // modem status levels and deltas
      cts_n[1] = 1'b0;
      idle(4);
      chk("R6", "irq on modem delta", int'(irq[1]), 1);
      rd(1, 3'd6, 8'h11, "R7");
      rd(1, 3'd6, 8'h10, "R8");
      idle(1);
      chk("R6", "irq after delta clear", int'(irq[1]), 0);
      // interrupt enables per condition
      tx_empty[1] = 1'b1;
      wr(4'b1101, 3'd1, 8'h02);
      idle(1);
      chk("R6", "irq tx_empty enabled", int'(irq[1]), 1);
      wr(4'b1101, 3'd1, 8'h01);
      idle(1);
      chk("R6", "irq tx_empty masked", int'(irq[1]), 0);
      chk("R5", "irq_oe ch1 off", int'(irq_oe[1]), 0);
      intsel = 1'b1;
      idle(1);
      chk("R5", "irq_oe forced", int'(irq_oe), 4'hF);
      // automatic flow control
      chk("R10", "tx blocked ch2", int'(tx_allowed[2]), 0);
      chk("R10", "tx free ch1", int'(tx_allowed[1]), 1);
      cts_n[2] = 1'b0;
      idle(3);
      chk("R10", "tx released ch2", int'(tx_allowed[2]), 1);
      // carrier and data-set-ready on channel 3
      cd_n[3] = 1'b0;
      idle(4);
      rd(3, 3'd6, 8'h88, "R7");
      dsr_n[3] = 1'b0;
      idle(4);
      rd(3, 3'd6, 8'hA2, "R8");
      // prescaler cadence
      count_baud(0, 4, "R9");
      count_baud(1, 16, "R9");
      wr(4'b1110, 3'd4, 8'h09);
      idle(1);
      count_baud(0, 16, "R9");
      wr(4'b1110, 3'd4, 8'h80);
      idle(1);
      count_baud(0, 4, "R9");
      // second reset with strap low
      clksel = 1'b0;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      rd(0, 3'd4, 8'h80, "R3");
      chk("R4", "dtr_n after second reset", int'(dtr_n[0]), 1);
      idle(8);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule